// File: doc/BRIEF.md
# Context Shadow Register Bank

This block holds a set of processor-visible registers, each backed by a hidden shadow copy. The shadow copies are never seen directly. A one-cycle command strobe moves values between each main register and its shadow. Four command types are supported:

- **Context store** saves state when entering a handler.
- **Context restore** brings the saved state back.
- **Masked bank exchange** swaps a selected subset of registers.
- **Address-pointer group swap** exchanges a selected subset of pointer registers.

The registers fall into five classes, placed one after another in a single index space:

- **Masked-exchange registers** swap only when their selection bit is set.
- **Save-only batch registers** copy in one direction. A store copies main into shadow, and a restore copies shadow into main.
- **Full-exchange batch registers** swap main and shadow on every store and every restore.
- **Address-pointer registers** swap on every store and restore. They can also be swapped in fixed-size groups by their own command.
- **Repeat counter** is a single register that joins store and restore only while a hold configuration bit is low.

A write port loads any main register by index. Every main register value is presented on one flat output bus. A context command always wins over a write issued in the same cycle. Instruction decoding and the datapath that consumes the registers are not part of this block.

Top module: `ctx_shadow_bank`

## Requirements
- R1: A synchronous active-high reset clears every main register and every shadow register to zero. After reset, a restore returns zero to all registers that take part in it.
- R2: Register index layout:
  - Masked-exchange registers occupy indices 0 to N_BANKX-1.
  - Save-only registers follow, then full-exchange registers, then pointer registers.
  - The repeat counter takes the last index, N_REGS-1.
  - Register k appears on `main_flat[k*DATA_W +: DATA_W]`.
  
  With `wr_en` high and no command, `wr_data` lands in register `wr_idx` on the next cycle. An index of N_REGS or above changes nothing.
- R3: A context store (`cmd_op`=0) copies each save-only main value into its shadow and leaves the save-only main values unchanged.
- R4: A context restore (`cmd_op`=1) copies each save-only shadow into its main register and leaves the shadow unchanged, so a second restore gives the same values.
- R5: Both store and restore fully exchange main and shadow of every full-exchange register and every pointer register.
- R6: A masked bank exchange (`cmd_op`=2) swaps masked-exchange register i with its shadow when `cmd_sel[i]` is 1. It leaves unselected registers, and all registers of the other classes, unchanged.
- R7: An address-pointer group swap (`cmd_op`=3) swaps every pointer register in group g when `cmd_sel[g]` is 1. Group g holds pointer registers g*PTR_GRP to g*PTR_GRP+PTR_GRP-1, counted from the first pointer index. Selection bits beyond the last group, and all registers outside the pointer class, are not affected.
- R8: The repeat counter exchanges with its shadow on store and restore only while `cfg_hold_rpt` is 0. While `cfg_hold_rpt` is 1, its main value and its shadow value are both unchanged.
- R9: When `cmd_valid` and `wr_en` are high in the same cycle, the command takes effect and the write is dropped entirely.
- R10: Every transfer completes in one clock cycle, and its result is visible on `main_flat` on the cycle after the strobe, for any sequence of commands and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 0 store, 1 restore, 2 masked exchange, 3 pointer group swap |
| cmd_sel | input | SEL_W | Selection mask for op 2 (per register) and op 3 (per group) |
| wr_en | input | 1 | Main register write enable |
| wr_idx | input | IDX_W | Index of the register to write |
| wr_data | input | DATA_W | Write data |
| cfg_hold_rpt | input | 1 | When 1, the repeat counter is kept out of store and restore |
| main_flat | output | N_REGS*DATA_W | All main register values, register k at bits k*DATA_W upward |

## Verification
The bench builds the bank with these parameters:

| Parameter | Value |
|---|---|
| DATA_W | 8 |
| N_BANKX | 3 |
| N_ONESIDE | 2 |
| N_TWOSIDE | 2 |
| N_PTR | 4 |
| PTR_GRP | 2 |

This gives twelve registers and a three-bit selection. With so few registers, the bench walks every masked-exchange mask and every pointer-group mask, including the selection bit that has no pointer group behind it. It also covers every command type both with and without a colliding write, and both settings of the hold bit. An arithmetic shadow model in the bench then follows a long pseudo-random mix of commands and writes, and every register is compared after each step.

// File: rtl/ctx_bank_pkg.sv
package ctx_bank_pkg;

    typedef enum logic [1:0] {
        CMD_STORE   = 2'd0,
        CMD_RESTORE = 2'd1,
        CMD_BANKX   = 2'd2,
        CMD_PTRSWAP = 2'd3
    } ctx_cmd_e;

    typedef enum logic [2:0] {
        KIND_BANKX,
        KIND_ONESIDE,
        KIND_TWOSIDE,
        KIND_PTR,
        KIND_RPT
    } ctx_kind_e;

    // Per-register transfer request produced by the command decoder.
    typedef struct packed {
        logic xchg;  // main <-> shadow
        logic save;  // main -> shadow
        logic load;  // shadow -> main
        logic wr;    // write port -> main
    } cell_act_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Register classes occupy consecutive index ranges.
    function automatic ctx_kind_e kind_of(input int unsigned idx,
                                          input int unsigned n_bx,
                                          input int unsigned n_os,
                                          input int unsigned n_ts,
                                          input int unsigned n_ptr);
        if (idx < n_bx)                     return KIND_BANKX;
        if (idx < n_bx + n_os)              return KIND_ONESIDE;
        if (idx < n_bx + n_os + n_ts)       return KIND_TWOSIDE;
        if (idx < n_bx + n_os + n_ts + n_ptr) return KIND_PTR;
        return KIND_RPT;
    endfunction

endpackage

// File: rtl/ctx_reg_cell.sv
module ctx_reg_cell
    import ctx_bank_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  cell_act_t         act,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] main_q,
    output logic [DATA_W-1:0] shadow_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            main_q   <= '0;
            shadow_q <= '0;
        end else if (act.xchg) begin
            main_q   <= shadow_q;
            shadow_q <= main_q;
        end else if (act.save) begin
            shadow_q <= main_q;
        end else if (act.load) begin
            main_q   <= shadow_q;
        end else if (act.wr) begin
            main_q   <= wr_data;
        end
    end

endmodule

// File: rtl/ctx_cmd_decode.sv
module ctx_cmd_decode
    import ctx_bank_pkg::*;
#(
    parameter int unsigned N_BANKX   = 4,
    parameter int unsigned N_ONESIDE = 3,
    parameter int unsigned N_TWOSIDE = 2,
    parameter int unsigned N_PTR     = 4,
    parameter int unsigned PTR_GRP   = 2,
    parameter int unsigned N_REGS    = 14,
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned IDX_W     = 4
) (
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic [SEL_W-1:0]         cmd_sel,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic                     cfg_hold_rpt,
    output cell_act_t [N_REGS-1:0]   act
);

    localparam int unsigned OFS_PTR = N_BANKX + N_ONESIDE + N_TWOSIDE;

    ctx_cmd_e op;
    logic     is_store, is_restore, is_ctx, is_bankx, is_ptrswap, wr_free;

    always_comb begin
        op         = ctx_cmd_e'(cmd_op);
        is_store   = cmd_valid && (op == CMD_STORE);
        is_restore = cmd_valid && (op == CMD_RESTORE);
        is_ctx     = is_store || is_restore;
        is_bankx   = cmd_valid && (op == CMD_BANKX);
        is_ptrswap = cmd_valid && (op == CMD_PTRSWAP);
        // Any command blocks the write port for this cycle.
        wr_free    = wr_en && !cmd_valid;
    end

    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        localparam ctx_kind_e KIND = kind_of(i, N_BANKX, N_ONESIDE, N_TWOSIDE, N_PTR);

        assign act[i].wr = wr_free && (wr_idx == IDX_W'(i));

        if (KIND == KIND_BANKX) begin : g_bx
            assign act[i].xchg = is_bankx && cmd_sel[i];
            assign act[i].save = 1'b0;
            assign act[i].load = 1'b0;
        end else if (KIND == KIND_ONESIDE) begin : g_os
            assign act[i].xchg = 1'b0;
            assign act[i].save = is_store;
            assign act[i].load = is_restore;
        end else if (KIND == KIND_TWOSIDE) begin : g_ts
            assign act[i].xchg = is_ctx;
            assign act[i].save = 1'b0;
            assign act[i].load = 1'b0;
        end else if (KIND == KIND_PTR) begin : g_ptr
            localparam int unsigned GRP = (i - OFS_PTR) / PTR_GRP;
            assign act[i].xchg = is_ctx || (is_ptrswap && cmd_sel[GRP]);
            assign act[i].save = 1'b0;
            assign act[i].load = 1'b0;
        end else begin : g_rpt
            assign act[i].xchg = is_ctx && !cfg_hold_rpt;
            assign act[i].save = 1'b0;
            assign act[i].load = 1'b0;
        end
    end

endmodule

// File: rtl/ctx_shadow_bank.sv
module ctx_shadow_bank
    import ctx_bank_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned N_BANKX   = 4,
    parameter int unsigned N_ONESIDE = 3,
    parameter int unsigned N_TWOSIDE = 2,
    parameter int unsigned N_PTR     = 4,
    parameter int unsigned PTR_GRP   = 2,
    localparam int unsigned N_REGS     = N_BANKX + N_ONESIDE + N_TWOSIDE + N_PTR + 1,
    localparam int unsigned N_PTR_GRPS = (N_PTR + PTR_GRP - 1) / PTR_GRP,
    localparam int unsigned SEL_W      = max2(N_BANKX, N_PTR_GRPS),
    localparam int unsigned IDX_W      = $clog2(N_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_valid,
    input  logic [1:0]                 cmd_op,
    input  logic [SEL_W-1:0]           cmd_sel,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       cfg_hold_rpt,
    output logic [N_REGS*DATA_W-1:0]   main_flat
);

    cell_act_t [N_REGS-1:0]     act;
    logic [N_REGS*DATA_W-1:0]   shadow_flat;

    ctx_cmd_decode #(
        .N_BANKX   (N_BANKX),
        .N_ONESIDE (N_ONESIDE),
        .N_TWOSIDE (N_TWOSIDE),
        .N_PTR     (N_PTR),
        .PTR_GRP   (PTR_GRP),
        .N_REGS    (N_REGS),
        .SEL_W     (SEL_W),
        .IDX_W     (IDX_W)
    ) dec_i (
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_sel      (cmd_sel),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .cfg_hold_rpt (cfg_hold_rpt),
        .act          (act)
    );

    for (genvar i = 0; i < N_REGS; i++) begin : g_cell
        ctx_reg_cell #(
            .DATA_W (DATA_W)
        ) cell_i (
            .clk      (clk),
            .rst      (rst),
            .act      (act[i]),
            .wr_data  (wr_data),
            .main_q   (main_flat[i*DATA_W +: DATA_W]),
            .shadow_q (shadow_flat[i*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/ctx_shadow_bank_chk.sv
module ctx_shadow_bank_chk
    import ctx_bank_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned N_BANKX   = 4,
    parameter int unsigned N_ONESIDE = 3,
    parameter int unsigned N_TWOSIDE = 2,
    parameter int unsigned N_PTR     = 4,
    parameter int unsigned PTR_GRP   = 2,
    localparam int unsigned N_REGS     = N_BANKX + N_ONESIDE + N_TWOSIDE + N_PTR + 1,
    localparam int unsigned N_PTR_GRPS = (N_PTR + PTR_GRP - 1) / PTR_GRP,
    localparam int unsigned SEL_W      = max2(N_BANKX, N_PTR_GRPS),
    localparam int unsigned IDX_W      = $clog2(N_REGS)
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cmd_valid,
    input logic [1:0]               cmd_op,
    input logic [SEL_W-1:0]         cmd_sel,
    input logic                     wr_en,
    input logic [IDX_W-1:0]         wr_idx,
    input logic [DATA_W-1:0]        wr_data,
    input logic                     cfg_hold_rpt,
    input logic [N_REGS*DATA_W-1:0] main_flat,
    input logic [N_REGS*DATA_W-1:0] shadow_flat
);

    localparam int unsigned OS_LO = N_BANKX * DATA_W;
    localparam int unsigned TS_LO = (N_BANKX + N_ONESIDE) * DATA_W;
    localparam int unsigned PT_LO = (N_BANKX + N_ONESIDE + N_TWOSIDE) * DATA_W;
    localparam int unsigned RP_LO = (N_REGS - 1) * DATA_W;
    localparam int unsigned TOP   = N_REGS * DATA_W;

    logic idx_ok;
    assign idx_ok = {1'b0, wr_idx} < (IDX_W+1)'(N_REGS);

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (main_flat == '0) && (shadow_flat == '0));

    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cmd_valid && idx_ok) |=>
            main_flat[$past(wr_idx)*DATA_W +: DATA_W] == $past(wr_data));

    p_store_keeps_main_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == CMD_STORE) |=> $stable(main_flat[TS_LO-1:OS_LO]));

    p_store_fills_shadow_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == CMD_STORE) |=>
            shadow_flat[TS_LO-1:OS_LO] == $past(main_flat[TS_LO-1:OS_LO]));

    p_restore_keeps_shadow_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == CMD_RESTORE) |=> $stable(shadow_flat[TS_LO-1:OS_LO]));

    p_batch_exchange_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == CMD_STORE || cmd_op == CMD_RESTORE)) |=>
            (main_flat[RP_LO-1:TS_LO] == $past(shadow_flat[RP_LO-1:TS_LO])) &&
            (shadow_flat[RP_LO-1:TS_LO] == $past(main_flat[RP_LO-1:TS_LO])));

    p_bankx_local_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == CMD_BANKX) |=> $stable(main_flat[TOP-1:OS_LO]));

    p_ptrswap_local_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == CMD_PTRSWAP) |=>
            $stable(main_flat[PT_LO-1:0]) && $stable(main_flat[TOP-1:RP_LO]));

    p_rpt_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cfg_hold_rpt) |=>
            $stable(main_flat[TOP-1:RP_LO]) && $stable(shadow_flat[TOP-1:RP_LO]));

    p_cmd_drops_write_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == CMD_BANKX && cmd_sel == '0) |=> $stable(main_flat));

endmodule

bind ctx_shadow_bank ctx_shadow_bank_chk #(
    .DATA_W    (DATA_W),
    .N_BANKX   (N_BANKX),
    .N_ONESIDE (N_ONESIDE),
    .N_TWOSIDE (N_TWOSIDE),
    .N_PTR     (N_PTR),
    .PTR_GRP   (PTR_GRP)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_sel      (cmd_sel),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .cfg_hold_rpt (cfg_hold_rpt),
    .main_flat    (main_flat),
    .shadow_flat  (shadow_flat)
);

// File: tb/ctx_shadow_bank_tb_top.sv
`timescale 1ns/1ps
module ctx_shadow_bank_tb_top;

    localparam int BW    = 8;
    localparam int BBX   = 3;
    localparam int BOS   = 2;
    localparam int BTS   = 2;
    localparam int BPTR  = 4;
    localparam int BGRP  = 2;
    localparam int N     = BBX + BOS + BTS + BPTR + 1;   // 12
    localparam int SELW  = 3;
    localparam int IDXW  = 4;
    localparam int O_OS  = BBX;
    localparam int O_TS  = BBX + BOS;
    localparam int O_PT  = BBX + BOS + BTS;
    localparam int O_RP  = N - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = '0;
    logic [SELW-1:0]   cmd_sel = '0;
    logic              wr_en = 1'b0;
    logic [IDXW-1:0]   wr_idx = '0;
    logic [BW-1:0]     wr_data = '0;
    logic              cfg_hold_rpt = 1'b0;
    logic [N*BW-1:0]   main_flat;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [BW-1:0] m_main [N];
    logic [BW-1:0] m_shad [N];
    logic [15:0]   lfsr = 16'hACE1;

    always #5 clk = ~clk;

    ctx_shadow_bank #(
        .DATA_W(BW), .N_BANKX(BBX), .N_ONESIDE(BOS), .N_TWOSIDE(BTS),
        .N_PTR(BPTR), .PTR_GRP(BGRP)
    ) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sel(cmd_sel), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .cfg_hold_rpt(cfg_hold_rpt), .main_flat(main_flat)
    );

    task automatic end_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic void model_swap(int i);
        logic [BW-1:0] t;
        t = m_main[i];
        m_main[i] = m_shad[i];
        m_shad[i] = t;
    endfunction

    // Reference behaviour taken from the requirements.
    function automatic void model_step(bit cv, logic [1:0] op, logic [SELW-1:0] sel,
                                       bit we, logic [IDXW-1:0] idx,
                                       logic [BW-1:0] data, bit hold);
        bit ctx;
        ctx = cv && (op == 2'd0 || op == 2'd1);
        if (cv) begin
            for (int i = 0; i < N; i++) begin
                if (i < O_OS) begin
                    if (op == 2'd2 && sel[i]) model_swap(i);
                end else if (i < O_TS) begin
                    if (op == 2'd0) m_shad[i] = m_main[i];
                    if (op == 2'd1) m_main[i] = m_shad[i];
                end else if (i < O_PT) begin
                    if (ctx) model_swap(i);
                end else if (i < O_RP) begin
                    if (ctx || (op == 2'd3 && sel[(i - O_PT) / BGRP])) model_swap(i);
                end else begin
                    if (ctx && !hold) model_swap(i);
                end
            end
        end else if (we && int'(idx) < N) begin
            m_main[idx] = data;
        end
    endfunction

    task automatic check_all(string tag);
        for (int i = 0; i < N; i++) begin
            logic [BW-1:0] got;
            got = main_flat[i*BW +: BW];
            checks++;
            if (got !== m_main[i]) begin
                failures++;
                $display("FAIL %s reg %0d got %h expected %h", tag, i, got, m_main[i]);
            end
        end
    endtask

    // Drive one cycle at a falling edge; compare at the next falling edge.
    task automatic step(bit cv, logic [1:0] op, logic [SELW-1:0] sel, bit we,
                        logic [IDXW-1:0] idx, logic [BW-1:0] data, bit hold, string tag);
        @(negedge clk);
        cmd_valid = cv; cmd_op = op; cmd_sel = sel;
        wr_en = we; wr_idx = idx; wr_data = data; cfg_hold_rpt = hold;
        model_step(cv, op, sel, we, idx, data, hold);
        @(negedge clk);
        cmd_valid = 1'b0; wr_en = 1'b0;
        check_all(tag);
    endtask

    task automatic wr(int idx, logic [BW-1:0] data, string tag);
        step(1'b0, 2'd0, '0, 1'b1, IDXW'(idx), data, 1'b0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        end_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_main[i] = '0; m_shad[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R1");

        // R2: fill every register, plus an out-of-range index.
        for (int i = 0; i < N; i++) wr(i, BW'(8'h10 + i * 7), "R2");
        wr(13, 8'hEE, "R2");
        // R1: restore right after reset brings zero shadows into play.
        step(1'b1, 2'd1, '0, 1'b0, '0, '0, 1'b0, "R1");
        for (int i = 0; i < N; i++) wr(i, BW'(8'hA0 + i), "R2");

        // R3/R5: store, then overwrite main values.
        step(1'b1, 2'd0, '0, 1'b0, '0, '0, 1'b0, "R3");
        for (int i = O_OS; i < N; i++) wr(i, BW'(8'h30 + i), "R2");
        // R4/R5: restore twice.
        step(1'b1, 2'd1, '0, 1'b0, '0, '0, 1'b0, "R4");
        step(1'b1, 2'd1, '0, 1'b0, '0, '0, 1'b0, "R4");
        step(1'b1, 2'd0, '0, 1'b0, '0, '0, 1'b0, "R5");

        // R6: every masked-exchange mask.
        for (int m = 0; m < 8; m++) begin
            wr(m % BBX, BW'(8'h50 + m), "R2");
            step(1'b1, 2'd2, SELW'(m), 1'b0, '0, '0, 1'b0, "R6");
        end

        // R7: every pointer-group selection, including the unused bit.
        for (int s = 0; s < 8; s++) begin
            wr(O_PT + (s % BPTR), BW'(8'h70 + s), "R2");
            step(1'b1, 2'd3, SELW'(s), 1'b0, '0, '0, 1'b0, "R7");
        end

        // R8: hold bit keeps the repeat counter out of store and restore.
        wr(O_RP, 8'h5A, "R2");
        step(1'b1, 2'd0, '0, 1'b0, '0, '0, 1'b1, "R8");
        wr(O_RP, 8'h6B, "R2");
        step(1'b1, 2'd1, '0, 1'b0, '0, '0, 1'b1, "R8");
        step(1'b1, 2'd0, '0, 1'b0, '0, '0, 1'b0, "R8");
        wr(O_RP, 8'h7C, "R2");
        step(1'b1, 2'd1, '0, 1'b0, '0, '0, 1'b0, "R8");
        step(1'b1, 2'd1, '0, 1'b0, '0, '0, 1'b1, "R8");

        // R9: a write in a command cycle is dropped, for every command type.
        for (int op = 0; op < 4; op++) begin
            step(1'b1, 2'(op), 3'b000, 1'b1, IDXW'(op * 3), 8'hC3, 1'b0, "R9");
            step(1'b1, 2'(op), 3'b101, 1'b1, IDXW'(O_RP), 8'hD4, 1'b1, "R9");
        end

        // R10: pseudo-random mix of commands and writes.
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] & lfsr[5], lfsr[2:1], lfsr[8:6], lfsr[3],
                 IDXW'(lfsr[12:9] % 13), lfsr[15:8], lfsr[4], "R10");
        end

        end_run();
    end

endmodule